// File: doc/BRIEF.md
# Serial Flash Block-Copy Sequencer

This block copies a contiguous region of a serial NOR flash into on-chip memory with no processor involvement. A caller presents a 24-bit flash start address, a destination address and a byte count, then pulses a start strobe. The sequencer drives the serial clock, chip select and data-out lines itself. Every byte it reads comes out on a one-cycle valid/address/data write port.

The copy is split into frames. Each frame opens with the plain read command and a 24-bit address, and carries at most 60 data bytes. That limit keeps a whole frame, header echo included, within 64 bytes. The four bytes the flash shifts back while the header goes out are dropped. Data bytes go straight to the write port. Between frames the chip select stays high for a programmable number of cycles, so that the flash's deselect time is met.

Top module: `flash_boot_seq`

## Requirements
- R1: Each frame shifts out the byte 0x03 and then the 24-bit flash address, most significant byte first. Serial mode 0 is used: MOSI changes while SCLK is low, and MISO is sampled on the SCLK rising edge, most significant bit first.
- R2: A frame carries min(remaining, MAX_CHUNK) data bytes (MAX_CHUNK = 60 by default), so it exchanges that count plus 4 bytes in total.
- R3: The 4 bytes received during the header are discarded. Each data byte is written through a one-cycle `wr_valid_o` pulse carrying its destination address and value. Writes occur only while busy.
- R4: After each frame, the flash address, the destination address and the remaining count all move by the frame's data length. The flash address wraps modulo 2^24.
- R5: Between two frames of one copy, chip select stays high for at least GAP_CYCLES clock cycles.
- R6: Each SCLK high and low phase lasts SCLK_DIV/2 clock cycles. SCLK is low whenever chip select is high.
- R7: `busy_o` rises the cycle after an accepted start and stays high until the last data byte has been written. In the next cycle `done_o` pulses for exactly one cycle, with `busy_o` low.
- R8: A start with length 0 gives `done_o` in the next cycle, never raises `busy_o` and never asserts chip select. Chip select is low only while busy.
- R9: A start pulse while busy is ignored: the running copy's frames and writes are unchanged, and no extra frame or write follows.
- R10: After reset, chip select is high, SCLK is low, and busy, done and write-valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| flash_addr_i | input | 24 | Flash start address |
| dest_addr_i | input | DEST_W | Destination start address |
| len_i | input | LEN_W | Number of bytes to copy |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle completion pulse |
| spi_cs_n_o | output | 1 | Flash chip select, active low |
| spi_sclk_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |
| wr_valid_o | output | 1 | Write strobe |
| wr_addr_o | output | DEST_W | Write address |
| wr_data_o | output | 8 | Write data byte |

## Verification
The bench targets lengths of 0, 1, exactly 60 and 61, plus multi-frame lengths. A chunking error shows up as a frame byte count that differs from the model's, or as a frame that should not be there. A copy that starts just below the top of the 24-bit space checks that the second frame's header address wraps. Without the wrap, the flash model would be sent an address that the expected-write queue rejects. A wrong echo discard shifts every written byte by one position, and a start pulse injected mid-copy would produce unexpected frames and writes if it were not ignored. The chip-select gap and the SCLK phase lengths are measured at the pins. The done pulse is checked against the cycle of the last write.

// File: rtl/fbs_pkg.sv
`timescale 1ns/1ps
package fbs_pkg;
    localparam int          FADDR_W   = 24;
    localparam int          HDR_BYTES = 4;
    localparam logic [7:0]  CMD_READ  = 8'h03;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_XFER,
        S_GAP,
        S_FINISH
    } seq_state_e;
endpackage

// File: rtl/fbs_spi_shift.sv
`timescale 1ns/1ps
// One-byte mode-0 shifter: MSB first, MISO sampled on SCLK rise.
module fbs_spi_shift #(
    parameter int SCLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic [7:0] rx_o
);
    localparam int HALF = (SCLK_DIV / 2 > 0) ? SCLK_DIV / 2 : 1;
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic          active;
        logic [HW-1:0] cnt;
        logic [2:0]    bitn;
        logic          sclk;
        logic [7:0]    sh;
        logic [7:0]    rx;
        logic          done;
    } sh_regs_t;

    sh_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start_i && !q.active) begin
            d.active = 1'b1;
            d.sh     = tx_i;
            d.bitn   = 3'd0;
            d.sclk   = 1'b0;
            d.cnt    = '0;
        end else if (q.active) begin
            if (q.cnt == HW'(HALF - 1)) begin
                d.cnt = '0;
                if (!q.sclk) begin
                    d.sclk = 1'b1;
                    d.rx   = {q.rx[6:0], miso_i};
                end else begin
                    d.sclk = 1'b0;
                    if (q.bitn == 3'd7) begin
                        d.active = 1'b0;
                        d.done   = 1'b1;
                    end else begin
                        d.bitn = q.bitn + 3'd1;
                        d.sh   = {q.sh[6:0], 1'b0};
                    end
                end
            end else begin
                d.cnt = q.cnt + HW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk_o = q.sclk;
    assign mosi_o = q.sh[7];
    assign done_o = q.done;
    assign rx_o   = q.rx;
endmodule

// File: rtl/fbs_gap_timer.sv
`timescale 1ns/1ps
// Counts cycles while run_i is high; flags the last one of GAP_CYCLES.
module fbs_gap_timer #(
    parameter int GAP_CYCLES = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int LIMIT = (GAP_CYCLES > 0) ? GAP_CYCLES : 1;
    localparam int GW    = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [GW-1:0] cnt_q, cnt_d;
    logic          hit;

    assign hit       = (cnt_q == GW'(LIMIT - 1));
    assign expired_o = run_i && hit;

    always_comb begin
        if (!run_i)  cnt_d = '0;
        else if (hit) cnt_d = cnt_q;
        else          cnt_d = cnt_q + GW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/flash_boot_seq.sv
`timescale 1ns/1ps
module flash_boot_seq
    import fbs_pkg::*;
#(
    parameter int DEST_W     = 32,
    parameter int LEN_W      = 24,
    parameter int MAX_CHUNK  = 60,
    parameter int SCLK_DIV   = 4,
    parameter int GAP_CYCLES = 125
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [23:0]        flash_addr_i,
    input  logic [DEST_W-1:0]  dest_addr_i,
    input  logic [LEN_W-1:0]   len_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               spi_cs_n_o,
    output logic               spi_sclk_o,
    output logic               spi_mosi_o,
    input  logic               spi_miso_i,
    output logic               wr_valid_o,
    output logic [DEST_W-1:0]  wr_addr_o,
    output logic [7:0]         wr_data_o
);
    localparam int FRAME_MAX = MAX_CHUNK + HDR_BYTES;
    localparam int IDX_W     = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        seq_state_e          state;
        logic [FADDR_W-1:0]  faddr;
        logic [DEST_W-1:0]   dest;
        logic [LEN_W-1:0]    remain;
        logic [IDX_W-1:0]    chunk;
        logic [IDX_W-1:0]    idx;
        logic                cs_n;
        logic                sh_start;
        logic [7:0]          sh_byte;
        logic                wr_valid;
        logic [DEST_W-1:0]   wr_addr;
        logic [7:0]          wr_data;
        logic                busy;
        logic                done;
    } seq_regs_t;

    seq_regs_t q, d;

    logic       sh_done;
    logic [7:0] sh_rx;
    logic       gap_expired;

    function automatic logic [7:0] hdr_byte(input logic [IDX_W-1:0] i,
                                            input logic [FADDR_W-1:0] a);
        logic [7:0] b;
        if      (i == IDX_W'(0)) b = CMD_READ;
        else if (i == IDX_W'(1)) b = a[23:16];
        else if (i == IDX_W'(2)) b = a[15:8];
        else if (i == IDX_W'(3)) b = a[7:0];
        else                     b = 8'h00;
        return b;
    endfunction

    fbs_spi_shift #(.SCLK_DIV(SCLK_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (q.sh_start),
        .tx_i    (q.sh_byte),
        .miso_i  (spi_miso_i),
        .sclk_o  (spi_sclk_o),
        .mosi_o  (spi_mosi_o),
        .done_o  (sh_done),
        .rx_o    (sh_rx)
    );

    fbs_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (q.state == S_GAP),
        .expired_o (gap_expired)
    );

    always_comb begin
        d          = q;
        d.sh_start = 1'b0;
        d.wr_valid = 1'b0;
        d.done     = 1'b0;
        case (q.state)
            S_IDLE: begin
                if (start_i) begin
                    if (len_i == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.busy   = 1'b1;
                        d.faddr  = flash_addr_i;
                        d.dest   = dest_addr_i;
                        d.remain = len_i;
                        d.state  = S_LOAD;
                    end
                end
            end
            S_LOAD: begin
                if (q.remain > LEN_W'(MAX_CHUNK)) d.chunk = IDX_W'(MAX_CHUNK);
                else                              d.chunk = q.remain[IDX_W-1:0];
                d.idx      = '0;
                d.cs_n     = 1'b0;
                d.sh_start = 1'b1;
                d.sh_byte  = hdr_byte('0, q.faddr);
                d.state    = S_XFER;
            end
            S_XFER: begin
                if (sh_done) begin
                    if (q.idx >= IDX_W'(HDR_BYTES)) begin
                        d.wr_valid = 1'b1;
                        d.wr_addr  = q.dest;
                        d.wr_data  = sh_rx;
                        d.dest     = q.dest + DEST_W'(1);
                    end
                    if (q.idx == q.chunk + IDX_W'(HDR_BYTES - 1)) begin
                        d.cs_n   = 1'b1;
                        d.faddr  = q.faddr + FADDR_W'(q.chunk);
                        d.remain = q.remain - LEN_W'(q.chunk);
                        d.state  = (q.remain == LEN_W'(q.chunk)) ? S_FINISH : S_GAP;
                    end else begin
                        d.idx      = q.idx + IDX_W'(1);
                        d.sh_start = 1'b1;
                        d.sh_byte  = hdr_byte(q.idx + IDX_W'(1), q.faddr);
                    end
                end
            end
            S_GAP: begin
                if (gap_expired) d.state = S_LOAD;
            end
            S_FINISH: begin
                d.busy  = 1'b0;
                d.done  = 1'b1;
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = q.busy;
    assign done_o     = q.done;
    assign spi_cs_n_o = q.cs_n;
    assign wr_valid_o = q.wr_valid;
    assign wr_addr_o  = q.wr_addr;
    assign wr_data_o  = q.wr_data;
endmodule

// File: rtl/fbs_checker.sv
`timescale 1ns/1ps
module fbs_checker #(
    parameter int MAX_CHUNK  = 60,
    parameter int GAP_CYCLES = 125
) (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic done_o,
    input logic spi_cs_n_o,
    input logic spi_sclk_o,
    input logic wr_valid_o
);
    localparam int MAX_RISES = 8 * (MAX_CHUNK + 4);

    logic        cs_prev_q, sclk_prev_q, had_frame_q;
    logic [31:0] gap_q, rises_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
            had_frame_q <= 1'b0;
            gap_q       <= '0;
            rises_q     <= '0;
        end else begin
            cs_prev_q   <= spi_cs_n_o;
            sclk_prev_q <= spi_sclk_o;
            if (!busy_o)                        had_frame_q <= 1'b0;
            else if (!cs_prev_q && spi_cs_n_o)  had_frame_q <= 1'b1;
            if (!spi_cs_n_o)                    gap_q <= '0;
            else if (gap_q != 32'hFFFF_FFFF)    gap_q <= gap_q + 32'd1;
            if (spi_cs_n_o)                     rises_q <= '0;
            else if (spi_sclk_o && !sclk_prev_q) rises_q <= rises_q + 32'd1;
        end
    end

    p_cs_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> spi_cs_n_o);
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n_o |-> !spi_sclk_o);
    p_write_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> busy_o);
    p_cs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_prev_q && !spi_cs_n_o && had_frame_q) |-> (gap_q >= 32'(GAP_CYCLES)));
    p_frame_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rises_q <= 32'(MAX_RISES));
endmodule

bind flash_boot_seq fbs_checker #(
    .MAX_CHUNK  (MAX_CHUNK),
    .GAP_CYCLES (GAP_CYCLES)
) u_fbs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .spi_cs_n_o (spi_cs_n_o),
    .spi_sclk_o (spi_sclk_o),
    .wr_valid_o (wr_valid_o)
);

// File: tb/flash_boot_seq_tb_top.sv
`timescale 1ns/1ps
module flash_boot_seq_tb_top;
    localparam int MAXC = 60;
    localparam int DIV  = 4;
    localparam int GAP  = 125;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] faddr = '0;
    logic [31:0] daddr = '0;
    logic [23:0] len = '0;
    logic        busy, done, cs_n, sclk, mosi, wr_valid;
    logic        miso = 1'b1;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;

    int errors = 0;
    int checks = 0;
    longint cyc = 0;
    longint last_wr_cyc = -10;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_boot_seq #(.MAX_CHUNK(MAXC), .SCLK_DIV(DIV), .GAP_CYCLES(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .flash_addr_i(faddr),
        .dest_addr_i(daddr), .len_i(len), .busy_o(busy), .done_o(done),
        .spi_cs_n_o(cs_n), .spi_sclk_o(sclk), .spi_mosi_o(mosi),
        .spi_miso_i(miso), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data));

    typedef struct { logic [31:0] a; logic [7:0] d; } wr_t;
    typedef struct { logic [23:0] a; int n; } frm_t;
    wr_t  wq[$];
    frm_t fq[$];

    function automatic logic [7:0] fmem(input logic [23:0] a);
        return a[7:0] + 8'd3 * a[15:8] + 8'd7 * a[23:16] + 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Flash model: mode 0, header echo drives ones.
    int          fbit = 0;
    logic [31:0] fcmd = '0;
    always @(negedge cs_n) begin fbit = 0; miso = 1'b1; end
    always @(posedge sclk) if (!cs_n) begin
        if (fbit < 32) fcmd = {fcmd[30:0], mosi};
        fbit++;
    end
    always @(negedge sclk) if (!cs_n && fbit >= 32) begin
        int k;
        logic [7:0] b;
        k = fbit - 32;
        b = fmem(fcmd[23:0] + 24'(k / 8));
        miso = b[7 - (k % 8)];
    end
    always @(posedge cs_n) if (rst_n) begin
        if (fq.size() == 0) begin
            chk(0, "R9", "unexpected frame", fbit, 0);
        end else begin
            frm_t f;
            f = fq.pop_front();
            chk(fcmd[31:24] == 8'h03, "R1", "command byte", fcmd[31:24], 8'h03);
            chk(fcmd[23:0] == f.a, "R4", "frame address", fcmd[23:0], f.a);
            chk(fbit == 8 * f.n, "R2", "frame bits", fbit, 8 * f.n);
        end
    end

    // Monitor: write scoreboard, CS gap, SCLK phase length.
    int  hi_cnt = 0, sclk_hi = 0;
    bit  prev_cs = 1, prev_sclk = 0, ended = 0;
    always @(negedge clk) if (rst_n) begin
        if (wr_valid) begin
            last_wr_cyc = cyc;
            if (wq.size() == 0) chk(0, "R3", "unexpected write", wr_addr, 0);
            else begin
                wr_t w;
                w = wq.pop_front();
                chk(wr_addr == w.a, "R3", "write address", wr_addr, w.a);
                chk(wr_data == w.d, "R3", "write data", wr_data, w.d);
            end
        end
        if (!busy) ended = 0;
        if (prev_cs && !cs_n && ended)
            chk(hi_cnt >= GAP, "R5", "cs high gap", hi_cnt, GAP);
        if (!prev_cs && cs_n && busy) ended = 1;
        hi_cnt = cs_n ? hi_cnt + 1 : 0;
        if (sclk) sclk_hi++;
        if (prev_sclk && !sclk) begin
            chk(sclk_hi == DIV / 2, "R6", "sclk high phase", sclk_hi, DIV / 2);
            sclk_hi = 0;
        end
        if (cs_n && sclk) chk(0, "R6", "sclk high with cs high", 1, 0);
        prev_cs = cs_n;
        prev_sclk = sclk;
    end

    task automatic run_copy(input logic [23:0] fa, input logic [31:0] da,
                            input int n, input int poke_at);
        int rem, c, waited;
        logic [23:0] a;
        for (int i = 0; i < n; i++) begin
            wr_t w;
            w.a = da + 32'(i);
            w.d = fmem(fa + 24'(i));
            wq.push_back(w);
        end
        rem = n; a = fa;
        while (rem > 0) begin
            frm_t f;
            c = (rem > MAXC) ? MAXC : rem;
            f.a = a; f.n = c + 4;
            fq.push_back(f);
            a = a + 24'(c);
            rem -= c;
        end
        @(negedge clk);
        faddr = fa; daddr = da; len = 24'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(done == 1'b1, "R8", "zero-length done", done, 1);
            chk(busy == 1'b0, "R8", "zero-length busy", busy, 0);
            @(negedge clk);
            chk(done == 1'b0, "R7", "done width", done, 0);
            return;
        end
        chk(busy == 1'b1, "R7", "busy after start", busy, 1);
        waited = 0;
        while (!done && waited < 60000) begin
            if (waited == poke_at && poke_at > 0) begin
                faddr = 24'h123456; daddr = 32'hDEAD0000; len = 24'd5; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                waited++;
            end else begin
                @(negedge clk);
                waited++;
            end
        end
        chk(done == 1'b1, "R7", "done seen", done, 1);
        chk(busy == 1'b0, "R7", "busy low at done", busy, 0);
        chk(last_wr_cyc == cyc - 1, "R7", "done follows last write", last_wr_cyc, cyc - 1);
        chk(wq.size() == 0, "R3", "writes left", wq.size(), 0);
        chk(fq.size() == 0, "R2", "frames left", fq.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R7", "done width", done, 0);
        chk(cs_n == 1'b1, "R8", "cs high idle", cs_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R10", "reset cs", cs_n, 1);
        chk(sclk == 1'b0, "R10", "reset sclk", sclk, 0);
        chk(busy == 1'b0 && done == 1'b0 && wr_valid == 1'b0, "R10", "reset flags",
            {busy, done, wr_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_copy(24'h000100, 32'h0000_1000, 0, 0);   // R8
        run_copy(24'h000100, 32'h0000_2000, 1, 0);   // R1 R3
        run_copy(24'h0A0000, 32'h0000_3000, 60, 0);  // R2 exact chunk
        run_copy(24'h0B0010, 32'h0000_4000, 61, 0);  // R2 R5 one-byte tail
        run_copy(24'h123400, 32'h8000_0000, 130, 0); // R4 three frames
        run_copy(24'hFFFFE0, 32'h0000_5000, 100, 0); // R4 address wrap
        run_copy(24'h00C000, 32'h0000_6000, 121, 400); // R9 start while busy
        repeat (20) @(negedge clk);
        chk(fq.size() == 0 && wq.size() == 0, "R9", "nothing after ignored start",
            fq.size() + wq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule